// File: doc/BRIEF.md
# PMIC Arbiter Software Command Channel

This block gives a processor a memory-mapped path for single register reads and writes to power-management slave devices. Software writes 32-bit words on a simple register bus. A write to the command register starts one transaction. That word holds the command class, a write flag, the slave ID, the byte count less one and the register address. The block then holds a request toward the device side until the device acknowledges it.

A write transaction ends at the acknowledge. A read transaction ends when the device returns its data. The read data is latched, and the channel then waits for software to acknowledge it through a valid-clear register. The channel's progress is shown as a 3-bit encoded state in the status register, and software polls that field. At most two bytes move per transaction. Bytes beyond the requested count are forced to zero in both directions.

The state machine has four states: IDLE (code 0), REQ (code 2), WFDLE (code 4, read acknowledged and waiting for data) and WFVLDCLR (code 6, read data held for software). Its transitions are:
- launch: IDLE to REQ on a command write.
- write-done: REQ to IDLE on acknowledge when the write flag is set.
- read-ack: REQ to WFDLE on acknowledge when the write flag is clear.
- data-return: WFDLE to WFVLDCLR when the device marks its data valid.
- release: WFVLDCLR to IDLE on a valid-clear write with bit 0 set.

Top module: `pmic_cmd_chan`

## Requirements
- R1: While reset is asserted, status (0x8E8), read data (0x8D4) and the ready word at 0x000 all read 0, and dev_req is low. From the first clock edge after reset is released, bit 15 of the word at 0x000 reads 1.
- R2: A write to 0x8C0 in IDLE captures the command word and launches a transaction. The word's fields are: class [31:30] (0 zero-register write, 1 short-address access, 2 extended access, 3 extended-long access), write flag [29] (1 = write), slave ID [27:24], byte count less one [23:16] and address [15:0]. The word reads back at 0x8C0 and drives the dev_* fields. On the next cycle the status state field [3:1] reads 2 and dev_req is high.
- R3: While in REQ, dev_req and every dev_* command field stay stable until dev_ack is sampled high.
- R4: A write transaction returns to IDLE on the cycle after dev_ack and never enters WFVLDCLR.
- R5: A read transaction moves to WFDLE (code 4) after dev_ack. When dev_rvalid is sampled, it latches the data and moves to WFVLDCLR (code 6).
- R6: WFVLDCLR is held until 0x8E4 is written with bit 0 = 1, which returns the channel to IDLE. A write to 0x8E4 with bit 0 = 0 has no effect.
- R7: dev_wdata is a copy of the write-data register at 0x8C4, taken at launch. A count field of 0 keeps 1 byte, and any larger value keeps 2 bytes. The other bytes are zero. Writing 0x8C4 during a transaction does not change dev_wdata.
- R8: The read-data register at 0x8D4 shows the returned bytes that fall within the count, with all other bytes reading zero. It holds its value until the next read returns data, including after the valid-clear.
- R9: A write to 0x8C0 outside IDLE is ignored, so the captured command and the state do not change, and it sets status bit 0. The bit is cleared only by writing 0x8E8 with bit 0 = 1.
- R10: A write to 0x8E8 never changes the state field. Writes to 0x8D4 and 0x000 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register-bus write strobe |
| bus_addr | input | ADDR_W | Register-bus byte offset |
| bus_wdata | input | 32 | Register-bus write data |
| bus_rdata | output | 32 | Register-bus read data for bus_addr (combinational) |
| dev_req | output | 1 | Request to the device side, high in REQ |
| dev_class | output | 2 | Command class of the running transaction |
| dev_write | output | 1 | 1 for a write transaction |
| dev_sid | output | 4 | Target slave ID |
| dev_bcnt | output | 8 | Byte count less one |
| dev_addr | output | 16 | Target register address |
| dev_wdata | output | MAX_BYTES*8 | Masked write payload |
| dev_ack | input | 1 | Device accepts the request |
| dev_rvalid | input | 1 | Device read data valid |
| dev_rdata | input | MAX_BYTES*8 | Device read data |

## Verification
The channel has to resolve two events in the same cycle: a device acknowledge and a software command write. The bench provokes this by issuing a second command write immediately after a write command, while the stub responder acknowledges with zero delay. Both therefore land on the same clock edge. The expected outcome is that the running write completes to IDLE, the new command is rejected with the error bit set, and the first command stays readable. The bench judges this with its cycle-by-cycle reference model and with directed status and command read-backs.

// File: rtl/pmic_cmd_chan_pkg.sv
package pmic_cmd_chan_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REQ      = 3'd2,
        ST_WFDLE    = 3'd4,
        ST_WFVLDCLR = 3'd6
    } chan_state_e;

    localparam logic [11:0] OFS_READY  = 12'h000;
    localparam logic [11:0] OFS_CMD    = 12'h8C0;
    localparam logic [11:0] OFS_WDATA  = 12'h8C4;
    localparam logic [11:0] OFS_RDATA  = 12'h8D4;
    localparam logic [11:0] OFS_VLDCLR = 12'h8E4;
    localparam logic [11:0] OFS_STATUS = 12'h8E8;

    localparam int READY_BIT = 15;

endpackage

// File: rtl/pmic_cmd_chan_dec.sv
module pmic_cmd_chan_dec
    import pmic_cmd_chan_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wbit0,
    input  logic              ready_q,
    input  logic [BUS_W-1:0]  cmd_q,
    input  logic [BUS_W-1:0]  wdata_q,
    input  logic [BUS_W-1:0]  rdata_q,
    input  logic [2:0]        state_code,
    input  logic              err_q,
    output logic              cmd_wr,
    output logic              wdata_wr,
    output logic              vldclr_wr,
    output logic              errclr_wr,
    output logic [BUS_W-1:0]  bus_rdata
);

    logic hit_cmd, hit_wdata, hit_rdata, hit_vldclr, hit_status, hit_ready;

    always_comb begin
        hit_cmd    = (bus_addr == ADDR_W'(OFS_CMD));
        hit_wdata  = (bus_addr == ADDR_W'(OFS_WDATA));
        hit_rdata  = (bus_addr == ADDR_W'(OFS_RDATA));
        hit_vldclr = (bus_addr == ADDR_W'(OFS_VLDCLR));
        hit_status = (bus_addr == ADDR_W'(OFS_STATUS));
        hit_ready  = (bus_addr == ADDR_W'(OFS_READY));
    end

    always_comb begin
        cmd_wr    = bus_we && hit_cmd;
        wdata_wr  = bus_we && hit_wdata;
        vldclr_wr = bus_we && hit_vldclr && wbit0;
        errclr_wr = bus_we && hit_status && wbit0;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ready)  bus_rdata[READY_BIT] = ready_q;
        if (hit_cmd)    bus_rdata = cmd_q;
        if (hit_wdata)  bus_rdata = wdata_q;
        if (hit_rdata)  bus_rdata = rdata_q;
        if (hit_status) bus_rdata = {{(BUS_W-4){1'b0}}, state_code, err_q};
    end

endmodule

// File: rtl/pmic_cmd_chan_fsm.sv
module pmic_cmd_chan_fsm
    import pmic_cmd_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        cmd_is_write,
    input  logic        dev_ack,
    input  logic        dev_rvalid,
    input  logic        vldclr_wr,
    output chan_state_e state,
    output logic        launch,
    output logic        reject,
    output logic        capture,
    output logic        dev_req
);

    chan_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_wr)     state_d = ST_REQ;
            ST_REQ:      if (dev_ack)    state_d = cmd_is_write ? ST_IDLE : ST_WFDLE;
            ST_WFDLE:    if (dev_rvalid) state_d = ST_WFVLDCLR;
            ST_WFVLDCLR: if (vldclr_wr)  state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state   = state_q;
        launch  = cmd_wr && (state_q == ST_IDLE);
        reject  = cmd_wr && (state_q != ST_IDLE);
        capture = dev_rvalid && (state_q == ST_WFDLE);
        dev_req = (state_q == ST_REQ);
    end

endmodule

// File: rtl/pmic_cmd_chan_mask.sv
module pmic_cmd_chan_mask #(
    parameter int MAX_BYTES = 2,
    localparam int PAY_W = MAX_BYTES * 8
) (
    input  logic [7:0]       bcnt,
    input  logic [PAY_W-1:0] data_in,
    output logic [PAY_W-1:0] data_out
);

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
        assign data_out[i*8 +: 8] = (bcnt >= 8'(i)) ? data_in[i*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/pmic_cmd_chan.sv
module pmic_cmd_chan
    import pmic_cmd_chan_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int MAX_BYTES = 2,
    localparam int PAY_W    = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              dev_req,
    output logic [1:0]        dev_class,
    output logic              dev_write,
    output logic [3:0]        dev_sid,
    output logic [7:0]        dev_bcnt,
    output logic [15:0]       dev_addr,
    output logic [PAY_W-1:0]  dev_wdata,
    input  logic              dev_ack,
    input  logic              dev_rvalid,
    input  logic [PAY_W-1:0]  dev_rdata
);

    logic [BUS_W-1:0] cmd_q, wdata_q, rdata_q;
    logic [PAY_W-1:0] wpay_q, wmask_out, rmask_out;
    logic             err_q, ready_q;
    logic             cmd_wr, wdata_wr, vldclr_wr, errclr_wr;
    logic             launch, reject, capture;
    chan_state_e      state;

    pmic_cmd_chan_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .wbit0      (bus_wdata[0]),
        .ready_q    (ready_q),
        .cmd_q      (cmd_q),
        .wdata_q    (wdata_q),
        .rdata_q    (rdata_q),
        .state_code (state),
        .err_q      (err_q),
        .cmd_wr     (cmd_wr),
        .wdata_wr   (wdata_wr),
        .vldclr_wr  (vldclr_wr),
        .errclr_wr  (errclr_wr),
        .bus_rdata  (bus_rdata)
    );

    pmic_cmd_chan_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_is_write (cmd_q[29]),
        .dev_ack      (dev_ack),
        .dev_rvalid   (dev_rvalid),
        .vldclr_wr    (vldclr_wr),
        .state        (state),
        .launch       (launch),
        .reject       (reject),
        .capture      (capture),
        .dev_req      (dev_req)
    );

    // payload snapshot uses the count of the command being launched
    pmic_cmd_chan_mask #(.MAX_BYTES(MAX_BYTES)) u_wmask (
        .bcnt     (bus_wdata[23:16]),
        .data_in  (wdata_q[PAY_W-1:0]),
        .data_out (wmask_out)
    );

    pmic_cmd_chan_mask #(.MAX_BYTES(MAX_BYTES)) u_rmask (
        .bcnt     (cmd_q[23:16]),
        .data_in  (dev_rdata),
        .data_out (rmask_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            wpay_q  <= '0;
            err_q   <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
            if (launch) begin
                cmd_q  <= bus_wdata;
                wpay_q <= wmask_out;
            end
            if (wdata_wr) wdata_q <= bus_wdata;
            if (capture)  rdata_q <= BUS_W'(rmask_out);
            if (reject)         err_q <= 1'b1;
            else if (errclr_wr) err_q <= 1'b0;
        end
    end

    always_comb begin
        dev_class = cmd_q[31:30];
        dev_write = cmd_q[29];
        dev_sid   = cmd_q[27:24];
        dev_bcnt  = cmd_q[23:16];
        dev_addr  = cmd_q[15:0];
        dev_wdata = wpay_q;
    end

endmodule

// File: rtl/pmic_cmd_chan_chk.sv
module pmic_cmd_chan_chk
    import pmic_cmd_chan_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit0,
    input logic              dev_req,
    input logic              dev_ack,
    input logic              dev_write,
    input logic              dev_rvalid,
    input logic [15:0]       dev_addr,
    input logic [3:0]        dev_sid,
    input logic [7:0]        dev_bcnt,
    input chan_state_e       state,
    input logic              err_q,
    input logic [BUS_W-1:0]  cmd_q,
    input logic [BUS_W-9:0]  rdata_hi
);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req && !dev_ack |=> dev_req && $stable(dev_addr) && $stable(dev_sid));

    // R4
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req && dev_ack && dev_write |=> state == ST_IDLE);

    // R5
    rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req && dev_ack && !dev_write |=> state == ST_WFDLE);

    // R6
    vld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WFVLDCLR && !(bus_we && bus_addr == ADDR_W'(OFS_VLDCLR) && wbit0)
        |=> state == ST_WFVLDCLR);

    // R9
    reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == ADDR_W'(OFS_CMD) && state != ST_IDLE
        |=> err_q && $stable(cmd_q));

    // R8
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WFDLE && dev_rvalid && dev_bcnt == 8'd0 |=> rdata_hi == '0);

endmodule

bind pmic_cmd_chan pmic_cmd_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wbit0      (bus_wdata[0]),
    .dev_req    (dev_req),
    .dev_ack    (dev_ack),
    .dev_write  (dev_write),
    .dev_rvalid (dev_rvalid),
    .dev_addr   (dev_addr),
    .dev_sid    (dev_sid),
    .dev_bcnt   (dev_bcnt),
    .state      (state),
    .err_q      (err_q),
    .cmd_q      (cmd_q),
    .rdata_hi   (rdata_q[31:8])
);

// File: tb/pmic_cmd_chan_test.sv
`timescale 1ns/1ps
module pmic_cmd_chan_test;

    localparam int AW = 12;
    localparam int MAXB = 2;
    localparam int PW = MAXB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          dev_req, dev_write;
    logic [1:0]    dev_class;
    logic [3:0]    dev_sid;
    logic [7:0]    dev_bcnt;
    logic [15:0]   dev_addr;
    logic [PW-1:0] dev_wdata;
    logic          dev_ack = 1'b0;
    logic          dev_rvalid = 1'b0;
    logic [PW-1:0] dev_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit cmp_on = 0;

    int          ack_delay = 0;
    int          rv_delay = 0;
    logic [15:0] resp_data = 16'h0;

    pmic_cmd_chan #(.ADDR_W(AW), .MAX_BYTES(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_req(dev_req),
        .dev_class(dev_class), .dev_write(dev_write), .dev_sid(dev_sid),
        .dev_bcnt(dev_bcnt), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
        .dev_ack(dev_ack), .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int unsigned m_state, m_cmd, m_wdata, m_rdata, m_pay;
    bit m_err, m_ready;

    function automatic int unsigned keep_bytes(int unsigned v, int unsigned bc);
        int unsigned n;
        longint unsigned msk;
        n = (bc + 1 < MAXB) ? bc + 1 : MAXB;
        msk = (64'd1 << (8 * n)) - 1;
        return v & int'(msk);
    endfunction

    function automatic int unsigned model_read(int unsigned a);
        case (a)
            32'h000: return m_ready ? 32'h8000 : 0;
            32'h8C0: return m_cmd;
            32'h8C4: return m_wdata;
            32'h8D4: return m_rdata;
            32'h8E8: return (m_state << 1) | int'(m_err);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int unsigned ns;
        bit cmd_hit;
        cmp_on = 1;
        if (!rst_n) begin
            m_state = 0; m_cmd = 0; m_wdata = 0; m_rdata = 0; m_pay = 0;
            m_err = 0; m_ready = 0;
        end else begin
            cmd_hit = bus_we && bus_addr == 12'h8C0;
            ns = m_state;
            case (m_state)
                0: if (cmd_hit) begin
                       ns = 2; m_cmd = bus_wdata;
                       m_pay = keep_bytes(m_wdata, bus_wdata[23:16]);
                   end
                2: if (dev_ack) ns = m_cmd[29] ? 0 : 4;
                4: if (dev_rvalid) begin
                       ns = 6; m_rdata = keep_bytes(32'(dev_rdata), m_cmd[23:16]);
                   end
                6: if (bus_we && bus_addr == 12'h8E4 && bus_wdata[0]) ns = 0;
                default: ns = 0;
            endcase
            if (cmd_hit && m_state != 0) m_err = 1;
            else if (bus_we && bus_addr == 12'h8E8 && bus_wdata[0]) m_err = 0;
            if (bus_we && bus_addr == 12'h8C4) m_wdata = bus_wdata;
            m_state = ns;
            m_ready = 1;
        end
    end

    always @(negedge clk) begin
        string t;
        if (cmp_on && !done) begin
            case (bus_addr)
                12'h000: t = "R1 ready word";
                12'h8C0: t = "R2 command readback";
                12'h8C4: t = "R7 wdata readback";
                12'h8D4: t = "R8 read data";
                default: t = "R9 status/other";
            endcase
            check(t, bus_rdata, model_read(32'(bus_addr)));
            check("R3 dev_req", 32'(dev_req), 32'(m_state == 2));
            if (m_state == 2) begin
                check("R2 dev fields",
                      {dev_class, dev_write, 1'b0, dev_sid, dev_bcnt, dev_addr},
                      m_cmd & 32'hEFFF_FFFF);
                check("R7 dev_wdata", 32'(dev_wdata), m_pay);
            end
        end
    end

    // ---------------- stub device responder ----------------
    initial begin
        logic wr;
        forever begin
            @(posedge clk); #1;
            if (dev_req) begin
                for (int k = 0; k < ack_delay; k++) begin @(posedge clk); #1; end
                wr = dev_write;
                dev_ack = 1'b1;
                @(posedge clk); #1;
                dev_ack = 1'b0;
                if (!wr) begin
                    for (int k = 0; k < rv_delay; k++) begin @(posedge clk); #1; end
                    dev_rdata = resp_data;
                    dev_rvalid = 1'b1;
                    @(posedge clk); #1;
                    dev_rvalid = 1'b0;
                    dev_rdata = 16'hDEAD;
                end
            end
        end
    end

    // ---------------- bus tasks (called at posedge+1) ----------------
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #4;
        check(tag, bus_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
    endtask

    task automatic peek(input string tag, input logic [31:0] act_sel, input logic [31:0] exp);
        check(tag, act_sel, exp);
    endtask

    task summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        idle(3);
        bus_read(12'h000, 32'h0, "R1 ready low in reset");
        rst_n = 1'b1;
        idle(1);
        bus_read(12'h000, 32'h8000, "R1 ready after release");
        bus_read(12'h8E8, 32'h0, "R1 status idle");
        bus_read(12'h8D4, 32'h0, "R1 rdata zero");
        check("R1 dev_req low", 32'(dev_req), 32'h0);

        // write, short access, 1 byte, slow acknowledge
        ack_delay = 3;
        bus_write(12'h8C4, 32'hA5C3_7E11);
        bus_write(12'h8C0, 32'h6500_001F);
        #4; check("R7 one-byte payload", 32'(dev_wdata), 32'h11);
        check("R2 dev_sid", 32'(dev_sid), 32'h5);
        @(posedge clk); #1;
        bus_read(12'h8E8, 32'h4, "R2 state REQ");
        bus_write(12'h8C4, 32'hFFFF_FFFF);
        #4; check("R7 payload held", 32'(dev_wdata), 32'h11);
        @(posedge clk); #1;
        idle(4);
        bus_read(12'h8E8, 32'h0, "R4 write back to IDLE");

        // write, extended-long, count clamps to 2 bytes
        ack_delay = 0;
        bus_write(12'h8C4, 32'h1234_9C63);
        bus_write(12'h8C0, 32'hE905_03A7);
        #4; check("R7 two-byte clamp", 32'(dev_wdata), 32'h9C63);
        @(posedge clk); #1;
        idle(2);
        bus_read(12'h8E8, 32'h0, "R4 idle after ack");

        // read, extended, 1 byte, slow data
        rv_delay = 3; resp_data = 16'hBE63;
        bus_write(12'h8C0, 32'h8400_0009);
        idle(1);
        bus_read(12'h8E8, 32'h8, "R5 WFDLE");
        idle(5);
        bus_read(12'h8E8, 32'hC, "R5 WFVLDCLR");
        bus_read(12'h8D4, 32'h63, "R8 masked byte");
        bus_write(12'h8E4, 32'h0);
        bus_read(12'h8E8, 32'hC, "R6 clear with bit0=0 ignored");
        bus_write(12'h8E4, 32'h1);
        bus_read(12'h8E8, 32'h0, "R6 released to IDLE");

        // read, 2 bytes
        rv_delay = 0; resp_data = 16'h8C9C;
        bus_write(12'h8C0, 32'h4E01_0000);
        idle(4);
        bus_read(12'h8D4, 32'h8C9C, "R8 two bytes");
        bus_write(12'h8E4, 32'h1);
        idle(1);
        bus_read(12'h8D4, 32'h8C9C, "R8 held after clear");

        // command rejected outside IDLE
        resp_data = 16'h5A7A;
        bus_write(12'h8C0, 32'h4F00_0010);
        idle(4);
        bus_write(12'h8C0, 32'h6100_0002);
        bus_read(12'h8E8, 32'hD, "R9 error set, state kept");
        bus_read(12'h8C0, 32'h4F00_0010, "R9 command unchanged");
        bus_write(12'h8E8, 32'h0000_000E);
        bus_read(12'h8E8, 32'hD, "R10 status write keeps state");
        bus_write(12'h8E4, 32'h1);
        bus_read(12'h8E8, 32'h1, "R9 error sticky");
        bus_write(12'h8E8, 32'h1);
        bus_read(12'h8E8, 32'h0, "R9 error cleared");

        // acknowledge and command write in the same cycle
        bus_write(12'h8C4, 32'h77);
        bus_write(12'h8C0, 32'h6300_0040);
        bus_write(12'h8C0, 32'h6200_0041);
        idle(2);
        bus_read(12'h8E8, 32'h1, "R9 coincident reject");
        bus_read(12'h8C0, 32'h6300_0040, "R9 coincident command kept");
        bus_write(12'h8E8, 32'h1);

        // read-only locations
        bus_write(12'h8D4, 32'hFFFF_FFFF);
        bus_write(12'h000, 32'h0);
        bus_read(12'h8D4, 32'h7A, "R10 rdata not writable");
        bus_read(12'h000, 32'h8000, "R10 ready not writable");

        // zero-register write class
        ack_delay = 2;
        bus_write(12'h8C4, 32'h55);
        bus_write(12'h8C0, 32'h2B00_0000);
        #4; check("R2 class zero-write", {30'h0, dev_class}, 32'h0);
        check("R2 write flag", 32'(dev_write), 32'h1);
        @(posedge clk); #1;
        idle(4);
        bus_read(12'h8E8, 32'h0, "R4 zero-write done");

        done = 1;
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 100000; k++) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired act=hung exp=finished");
            summary();
            $finish;
        end
    end

endmodule